// File: doc/BRIEF.md
# Strap-Configured Management Bus Slave

This block lets an embedded management processor reach a small internal register space over a synchronous parallel bus. The bus has separate inputs for the address strobe, chip select, read/write control and word address, and a 16-bit data bus split into input, output and output-enable. The slave answers each access with a ready strobe and a 16-bit width acknowledge. It also drives one interrupt line, whose active level is set by software.

Five strap inputs are captured once, on the first clock edge after the asynchronous reset is released. They stay fixed until the next reset. The straps set four things:
- the clock mode: one edge per bus state, or two edges per bus state;
- the byte order on the data bus;
- the sense of the read/write control;
- whether ready comes in the same clock as the read data or one bus state before it.

The register file has 16 words. Word 0 bit 0 sets the interrupt polarity. Word 1 bit 0 is the interrupt pending flag. An internal event input sets the flag, and writing 1 to it clears the flag.

Top module: `strap_bus_slave`

## Requirements
- R1: `strap_i` is captured on the first rising clock edge with `rst_ni` high and is held until the next reset. Later changes on `strap_i` have no effect.
- R2: A bus cycle starts only on a clock edge where `ads_ni` and `cs_ni` are both low.
  - While the cycle lasts, `bs16_no` is low: 2 clocks in 1X mode and 5 clocks in 2X mode. It is high at all other times.
  - A strobe without chip select, or a chip select without strobe, starts nothing.
- R3: Read data latency depends on the clock mode.
  - With `strap_i[0]`=0 (1X), read data is valid from 2 clocks after the start edge, for 1 clock.
  - With `strap_i[0]`=1 (2X), read data is valid from 4 clocks after the start edge, for 2 clocks.
- R4: With `strap_i[1]`=1 (big endian), the two bytes are exchanged between the data bus and the registers, in both directions.
  - For example, bus bit 8 lands in register bit 0.
  - With `strap_i[1]`=0, no bytes are exchanged.
- R5: The meaning of `rwc_i` depends on `strap_i[2]`.
  - With `strap_i[2]`=0, `rwc_i`=1 means read and 0 means write.
  - With `strap_i[2]`=1, `rwc_i`=0 means read and 1 means write.
- R6: With `strap_i[4]`=1, `rdy_no` is low in exactly the clocks in which read data is valid.
- R7: With `strap_i[4]`=0, `rdy_no` goes low one bus state before the data window opens (1 clock in 1X, 2 clocks in 2X) and stays low for one bus state. Write cycles use the same ready timing.
- R8: `strap_i[3]` is latched but has no effect on bus behaviour.
- R9: `data_oe_o` is high only during the data window of a read cycle. Write cycles never drive the bus.
- R10: Address bits [3:0] of `addr_i` select one of 16 words.
  - If any of bits [10:4] is set, a read returns 0 and a write changes nothing.
- R11: The interrupt output follows word 0 bit 0 and word 1 bit 0.
  - Word 0 bit 0 = 1 makes `irq_o` active high; 0 makes it active low.
  - Word 1 bit 0 is the pending flag. A pulse on `irq_set_i` sets it, and writing a 1 to it clears it.
  - Word 1 reads as zero in bits [15:1].
- R12: In reset, `rdy_no`, `bs16_no` and `irq_o` are high and `data_oe_o` is low. `irq_o` is high because the polarity resets to active low and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 5 | Configuration straps, captured as reset ends |
| ads_ni | input | 1 | Address strobe, active low |
| cs_ni | input | 1 | Chip select, active low |
| rwc_i | input | 1 | Read/write control, sense set by strap bit 2 |
| addr_i | input | 11 | Word address (bus address bits 11:1) |
| data_i | input | 16 | Data bus, input side |
| data_o | output | 16 | Data bus, output side |
| data_oe_o | output | 1 | Data bus output enable |
| rdy_no | output | 1 | Ready, active low |
| bs16_no | output | 1 | 16-bit width acknowledge, active low |
| irq_set_i | input | 1 | Internal event that sets the pending flag |
| irq_o | output | 1 | Interrupt request, software-set polarity |

## Verification
The hardest state to reach is a configuration that exists only because of the straps sampled at the end of reset. Such a configuration is 2X clocking combined with early ready, or big endian combined with inverted read/write sense. The bench therefore applies each strap pattern through a fresh reset and then drives the opposite pattern onto the straps for the rest of the run. Reaching the expected behaviour then shows both the capture and the hold. Byte swapping is invisible on a plain write and read-back, so it is exposed through the interrupt polarity bit: after a big-endian write of 0x0100, the level of `irq_o` shows which register bit was written.

// File: rtl/strap_bus_pkg.sv
package strap_bus_pkg;
  typedef struct packed {
    logic rdy_same;   // strap 4
    logic width_ign;  // strap 3, no effect
    logic rw_inv;     // strap 2
    logic big_end;    // strap 1
    logic clk_2x;     // strap 0
  } strap_cfg_t;

  function automatic logic [15:0] swap16(input logic [15:0] d, input logic en);
    return en ? {d[7:0], d[15:8]} : d;
  endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch
  import strap_bus_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [4:0] strap_i,
  output strap_cfg_t cfg_o,
  output logic       vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
      vld_o <= 1'b0;
    end else if (!vld_o) begin
      cfg_o <= strap_cfg_t'(strap_i);
      vld_o <= 1'b1;
    end
  end
endmodule

// File: rtl/bus_timer.sv
module bus_timer #(
  parameter int AW     = 11,
  parameter int LAT_1X = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_vld_i,
  input  logic          clk_2x_i,
  input  logic          rdy_same_i,
  input  logic          rw_inv_i,
  input  logic          ads_ni,
  input  logic          cs_ni,
  input  logic          rwc_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic          is_rd_o,
  output logic [AW-1:0] addr_o,
  output logic          commit_o,
  output logic          data_win_o,
  output logic          rdy_o
);
  localparam int CNT_W = $clog2(2 * LAT_1X + 2);

  logic [CNT_W-1:0] cnt_q, lat, unit, last;
  logic             start;

  always_comb begin
    unit = clk_2x_i ? CNT_W'(2) : CNT_W'(1);
    lat  = clk_2x_i ? CNT_W'(2 * LAT_1X) : CNT_W'(LAT_1X);
    last = lat + unit - CNT_W'(1);
  end

  assign start = !busy_o && cfg_vld_i && !ads_ni && !cs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      cnt_q   <= '0;
      is_rd_o <= 1'b0;
      addr_o  <= '0;
    end else if (start) begin
      busy_o  <= 1'b1;
      cnt_q   <= CNT_W'(1);
      is_rd_o <= rw_inv_i ? !rwc_i : rwc_i;
      addr_o  <= addr_i;
    end else if (busy_o) begin
      if (cnt_q == last) begin
        busy_o <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  logic early_win;
  assign commit_o   = busy_o && (cnt_q == lat - CNT_W'(1));
  assign data_win_o = busy_o && (cnt_q >= lat);
  assign early_win  = busy_o && (cnt_q >= lat - unit) && (cnt_q < lat);
  assign rdy_o      = rdy_same_i ? data_win_o : early_win;
endmodule

// File: rtl/slave_regfile.sv
module slave_regfile #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int AW    = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          irq_set_i,
  output logic [DW-1:0] rdata_o,
  output logic          pol_o,
  output logic          pend_o
);
  localparam int IW = $clog2(DEPTH);

  logic          hit;
  logic [IW-1:0] idx;
  logic [DW-1:0] words [DEPTH];

  assign hit = (addr_i[AW-1:IW] == '0);
  assign idx = addr_i[IW-1:0];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    if (gi == 1) begin : g_pend
      logic pend_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                           pend_q <= 1'b0;
        else if (irq_set_i)                                    pend_q <= 1'b1;
        else if (we_i && hit && idx == IW'(gi) && wdata_i[0])  pend_q <= 1'b0;
      end
      assign words[gi] = {{(DW-1){1'b0}}, pend_q};
    end else begin : g_store
      logic [DW-1:0] word_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                               word_q <= '0;
        else if (we_i && hit && idx == IW'(gi))    word_q <= wdata_i;
      end
      assign words[gi] = word_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= hit ? words[idx] : '0;
  end

  assign pol_o  = words[0][0];
  assign pend_o = words[1][0];
endmodule

// File: rtl/strap_bus_slave.sv
module strap_bus_slave
  import strap_bus_pkg::*;
#(
  parameter int AW     = 11,
  parameter int DW     = 16,
  parameter int DEPTH  = 16,
  parameter int LAT_1X = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [4:0]    strap_i,
  input  logic          ads_ni,
  input  logic          cs_ni,
  input  logic          rwc_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          rdy_no,
  output logic          bs16_no,
  input  logic          irq_set_i,
  output logic          irq_o
);
  strap_cfg_t    cfg;
  logic          cfg_vld;
  logic          busy, is_rd, commit, data_win, rdy;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rdata, wdata;
  logic          pol, pend;

  strap_latch u_straps (
    .clk_i, .rst_ni, .strap_i,
    .cfg_o (cfg),
    .vld_o (cfg_vld)
  );

  bus_timer #(.AW(AW), .LAT_1X(LAT_1X)) u_timer (
    .clk_i, .rst_ni,
    .cfg_vld_i  (cfg_vld),
    .clk_2x_i   (cfg.clk_2x),
    .rdy_same_i (cfg.rdy_same),
    .rw_inv_i   (cfg.rw_inv),
    .ads_ni, .cs_ni, .rwc_i, .addr_i,
    .busy_o     (busy),
    .is_rd_o    (is_rd),
    .addr_o     (addr_q),
    .commit_o   (commit),
    .data_win_o (data_win),
    .rdy_o      (rdy)
  );

  assign wdata = swap16(data_i, cfg.big_end);

  slave_regfile #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (commit && !is_rd),
    .re_i      (commit && is_rd),
    .addr_i    (addr_q),
    .wdata_i   (wdata),
    .irq_set_i,
    .rdata_o   (rdata),
    .pol_o     (pol),
    .pend_o    (pend)
  );

  assign data_o    = swap16(rdata, cfg.big_end);
  assign data_oe_o = data_win && is_rd;
  assign rdy_no    = !rdy;
  assign bs16_no   = !busy;
  assign irq_o     = pol ? pend : !pend;
endmodule

// File: rtl/strap_bus_slave_chk.sv
module strap_bus_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] cfg_i,
  input logic       cfg_vld_i,
  input logic       is_rd_i,
  input logic       pend_i,
  input logic       irq_set_i,
  input logic       data_oe_o,
  input logic       rdy_no,
  input logic       bs16_no
);
  // R1
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_vld_i && $past(cfg_vld_i) |-> $stable(cfg_i));
  // R9
  oe_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !bs16_no);
  // R6
  rdy_same_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i[4] && is_rd_i && !bs16_no |-> (!rdy_no == data_oe_o));
  // R7
  rdy_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i[4] && $rose(data_oe_o) |-> $past(!rdy_no));
  // R11
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_i |=> pend_i);
  // R2
  rdy_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_no |-> !bs16_no);
endmodule

bind strap_bus_slave strap_bus_slave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_i     (cfg),
  .cfg_vld_i (cfg_vld),
  .is_rd_i   (is_rd),
  .pend_i    (pend),
  .irq_set_i (irq_set_i),
  .data_oe_o (data_oe_o),
  .rdy_no    (rdy_no),
  .bs16_no   (bs16_no)
);

// File: tb/strap_bus_slave_tb.sv
module strap_bus_slave_tb;
  logic        clk_i = 0, rst_ni = 0;
  logic [4:0]  strap_i = '0;
  logic        ads_ni = 1, cs_ni = 1, rwc_i = 0, irq_set_i = 0;
  logic [10:0] addr_i = '0;
  logic [15:0] data_i = '0, data_o;
  logic        data_oe_o, rdy_no, bs16_no, irq_o;

  strap_bus_slave u_dut (.*);

  always #4 clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit x2, big, rwinv, same;
  logic [15:0] mdl [16];
  bit mpend;
  logic [15:0] expq [$];
  bit oe_prev = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sw(input logic [15:0] d);
    return big ? {d[7:0], d[15:8]} : d;
  endfunction

  function automatic logic [15:0] exp_read(input logic [10:0] a);
    logic [15:0] v;
    if (a[10:4] != 0) return 16'h0;
    v = (a[3:0] == 1) ? {15'b0, mpend} : mdl[a[3:0]];
    return sw(v);
  endfunction

  function automatic bit exp_irq();
    return mdl[0][0] ? mpend : !mpend;
  endfunction

  // monitor: pop expectation on first clock of each read data window
  always @(negedge clk_i) begin
    if (rst_ni && data_oe_o && !oe_prev) begin
      if (expq.size() == 0) chk(0, "R3 unexpected data", data_o, 0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(data_o === e, "R3/R4/R10 read data", data_o, e);
      end
    end
    oe_prev = data_oe_o;
  end

  task automatic do_reset(input logic [4:0] s);
    rst_ni = 0; strap_i = s;
    repeat (3) @(negedge clk_i);
    chk(rdy_no && bs16_no && irq_o && !data_oe_o, "R12 reset outputs",
        {rdy_no, bs16_no, irq_o, data_oe_o}, 4'b1110);
    rst_ni = 1;
    @(negedge clk_i);
    strap_i = ~s;  // R1: later strap changes must be ignored
    x2 = s[0]; big = s[1]; rwinv = s[2]; same = s[4];
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    mpend = 0;
  endtask

  task automatic bus(input bit rd, input logic [10:0] a, input logic [15:0] w);
    int u, l, fo, fr, no, nr, nb;
    u = x2 ? 2 : 1; l = 2 * u;
    fo = -1; fr = -1; no = 0; nr = 0; nb = 0;
    if (rd) expq.push_back(exp_read(a));
    @(negedge clk_i);
    ads_ni = 0; cs_ni = 0; addr_i = a; data_i = w;
    rwc_i = rwinv ? !rd : rd;  // R5 encoding
    for (int k = 1; k <= l + u; k++) begin
      @(negedge clk_i);
      ads_ni = 1; cs_ni = 1;
      if (!bs16_no) nb++;
      if (data_oe_o) begin no++; if (fo < 0) fo = k; end
      if (!rdy_no)   begin nr++; if (fr < 0) fr = k; end
    end
    chk(nb == l + u - 1, "R2 bs16 length", nb, l + u - 1);
    chk(fr == (same ? l : l - u), same ? "R6 ready timing" : "R7 ready timing", fr, same ? l : l - u);
    chk(nr == u, "R7 ready length", nr, u);
    if (rd) begin
      chk(fo == l, "R3 data latency", fo, l);
      chk(no == u, "R3 data window", no, u);
    end else begin
      logic [15:0] v;
      chk(no == 0, "R9 no drive on write", no, 0);
      v = sw(w);
      if (a[10:4] == 0) begin
        if (a[3:0] == 1) begin if (v[0]) mpend = 0; end
        else mdl[a[3:0]] = v;
      end
    end
  endtask

  task automatic pulse_irq();
    @(negedge clk_i); irq_set_i = 1;
    @(negedge clk_i); irq_set_i = 0; mpend = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // mode A: 1X, little endian, rwc high=read, early ready
    do_reset(5'b00000);
    bus(0, 11'h002, 16'hA55A);
    bus(1, 11'h002, 0);
    bus(0, 11'h003, 16'h1234);
    bus(1, 11'h003, 0);
    // R10: out of range, aliases word 2 in low bits
    bus(0, 11'h012, 16'hFFFF);
    bus(1, 11'h012, 0);
    bus(1, 11'h002, 0);
    // R2: strobe without select and select without strobe
    @(negedge clk_i); ads_ni = 0; cs_ni = 1;
    @(negedge clk_i); chk(bs16_no, "R2 ads alone", bs16_no, 1);
    ads_ni = 1; cs_ni = 0;
    @(negedge clk_i); chk(bs16_no, "R2 cs alone", bs16_no, 1);
    cs_ni = 1;
    // R11 interrupt
    pulse_irq();
    @(negedge clk_i); chk(irq_o == exp_irq(), "R11 pending active low", irq_o, exp_irq());
    bus(1, 11'h001, 0);
    bus(0, 11'h001, 16'h0001);
    @(negedge clk_i); chk(irq_o == exp_irq(), "R11 w1c clear", irq_o, exp_irq());
    bus(0, 11'h000, 16'h0001);
    @(negedge clk_i); chk(irq_o == exp_irq(), "R11 polarity high", irq_o, exp_irq());
    pulse_irq();
    @(negedge clk_i); chk(irq_o == exp_irq(), "R11 pending active high", irq_o, exp_irq());

    // mode B: 2X, big endian, inverted rwc, same-clock ready
    do_reset(5'b10111);
    bus(0, 11'h004, 16'h1234);
    bus(1, 11'h004, 0);  // R5 R4 round trip
    bus(0, 11'h000, 16'h0100);
    @(negedge clk_i); chk(irq_o == 1'b0, "R4 swap sets polarity bit", irq_o, 0);
    bus(1, 11'h000, 0);
    pulse_irq();
    bus(1, 11'h001, 0);  // pending reads back swapped

    // mode C: strap 3 set, otherwise mode A (R8)
    do_reset(5'b01000);
    bus(0, 11'h007, 16'h00C3);
    bus(1, 11'h007, 0);

    // mode D: 2X, early ready
    do_reset(5'b00001);
    bus(0, 11'h00F, 16'hBEEF);
    bus(1, 11'h00F, 0);

    // mode E: 1X, same-clock ready
    do_reset(5'b10000);
    bus(0, 11'h009, 16'h5A0F);
    bus(1, 11'h009, 0);

    repeat (4) @(negedge clk_i);
    chk(expq.size() == 0, "R3 pending expectations", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule